// File: doc/BRIEF.md
# Video Decoder Control Register Slave

This block is a two-wire serial slave that holds the thirteen 8-bit control registers of a video decoder and answers reads with a single status byte. A host writes a frame of the form START, device address, register index, data, data, … , STOP. Each data byte lands in the indexed register, and the index then steps forward by one. A read frame returns the live decoder status, packed into one byte.

The serial lines pass through a synchroniser that runs on the system clock. START and STOP are recognised from SDA edges that occur while SCL is high. SDA is driven only as an open-drain pull-down enable. Every control register is presented as one flat parallel bus, and byte k of that bus holds register k. One input pin selects which of two device addresses the slave answers to.

Top module: `vdec_ctrl_regs`

## Requirements
- R1: After reset, `ctrl_o` bytes 0x0..0xC hold 0x7D, 0x7C, 0x77, 0x77, 0x74, 0x78, 0x77, 0x77, 0x78, 0x79, 0x78, 0x00, 0x14, and SDA is released.
- R2: With `addr_sel_i`=1 the slave answers to write byte 0x9A and read byte 0x9B. With `addr_sel_i`=0 it answers to 0x9E and 0x9F. Any other address byte gets no ACK, and the rest of that frame changes nothing.
- R3: In the index byte only bits 3..0 matter. Bits 7..4 are ignored (0xF3 selects register 0x3).
- R4: Each data byte of an addressed write frame is acknowledged and stored in register k, which is `ctrl_o[8k+7:8k]`. `ctrl_o` changes at no other time.
- R5: After each data byte the index advances by one. A byte whose index lies in 0xD..0xF is acknowledged and discarded.
- R6: A read returns {lock, killer, pal, field50, secam, fsc443, 0, 0} from bit 7 down. The value is captured at the address ACK and again at each master ACK, so it stays fixed while the byte is shifted out.
- R7: When the master answers a read byte with NACK, SDA is released and the slave idles. Further SCL pulses without a START cause no drive.
- R8: A repeated START begins a new frame from any point. A STOP in the middle of a byte discards the partial byte.
- R9: SDA is pulled low only in ACK slots and in zero bits of read data, and the pull-down changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| addr_sel_i | input | 1 | Device address select |
| hlock_i | input | 1 | Line oscillator locked |
| killer_i | input | 1 | Colour killer active |
| pal_i | input | 1 | PAL detected (0 = NTSC) |
| field50_i | input | 1 | 50 Hz field rate detected |
| secam_i | input | 1 | SECAM detected |
| fsc443_i | input | 1 | Subcarrier is 4.43 MHz |
| ctrl_o | output | 104 | Control registers, byte k = register k |

## Verification
Several write patterns are used. Single-byte writes show that data reaches the right byte lane. Multi-byte bursts that run past 0xC separate correct auto-increment from wrap-around or out-of-range corruption. An index with its high nibble set shows that only four bits are decoded. Frames sent to the other select's address check that a mismatch is neither acknowledged nor stored.

Reads use distinct status patterns, multi-byte reads, and a status change part-way through a byte; these separate a byte latched once from one sampled live. Repeated START, a STOP in mid-byte, and SCL pulses after a NACK cover the framing corners.

// File: rtl/vdec_i2c_pkg.sv
`timescale 1ns/1ps
package vdec_i2c_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_REGS = 13;
  localparam int unsigned SUB_W    = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK} bus_state_e;
  typedef enum logic [1:0] {PH_ADDR, PH_SUB, PH_DATA} rx_phase_e;

  // field packing of reset values, msb first
  function automatic logic [BYTE_W-1:0] reg_reset(input int unsigned idx);
    case (idx)
      0:  reg_reset = {6'h1F, 1'b0, 1'b1};          // hue, blk_exp_off, yc_sel
      1:  reg_reset = {6'h1F, 1'b0, 1'b0};          // color, mask, canal
      2:  reg_reset = {4'h7, 4'h7};                 // sharp, sub_contrast
      3:  reg_reset = {4'h7, 4'h7};                 // sub_hue, sub_color
      4:  reg_reset = {4'h7, 2'd1, 1'b0, 1'b0};     // trap_adj, afc_gain, trap_en, tot_en
      5:  reg_reset = {5'h0F, 1'b0, 1'b0, 1'b0};    // y_gain, shp_f0, fsc_out, vsync_fast
      6:  reg_reset = {4'h7, 4'h7};                 // u_ped, v_ped
      7:  reg_reset = {4'h7, 4'h7};                 // u2_ped, v2_ped
      8:  reg_reset = {5'h0F, 3'd0};                // y2_gain, dc_ratio
      9:  reg_reset = {5'h0F, 2'd0, 1'b1};          // u2_gain, pre_over, abl_off
      10: reg_reset = {5'h0F, 2'd0, 1'b0};          // v2_gain, abl_centre, abl_low
      11: reg_reset = {2'd0, 2'd0, 2'd0, 2'd0};     // sys_sel, xtal_sel, vfreq_mode, y_delay
      12: reg_reset = {2'd0, 2'd1, 2'd1, 1'b0, 1'b0}; // id_set, bgp_fall, bgp_rise, ext_chroma, spare
      default: reg_reset = '0;
    endcase
  endfunction
endpackage

// File: rtl/vdec_in_sync.sv
`timescale 1ns/1ps
module vdec_in_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '1;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/vdec_i2c_engine.sv
`timescale 1ns/1ps
module vdec_i2c_engine
  import vdec_i2c_pkg::*;
#(
  parameter logic [BYTE_W-2:0] ADDR_HI = 7'h4D,
  parameter logic [BYTE_W-2:0] ADDR_LO = 7'h4F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_oe_o,
  output logic              sub_ld_o,
  output logic              data_we_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              idle_o,
  output logic              rx_o,
  output logic              tx_o,
  output logic              start_o,
  output logic [BYTE_W-1:0] stat_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  bus_state_e        state_q;
  rx_phase_e         phase_q;
  logic              rd_q, mack_q, scl_q, sda_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, stat_q;

  logic scl_rise, scl_fall, start_det, stop_det, byte_end, addr_hit;
  logic [BYTE_W-2:0] own_addr;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign own_addr  = addr_sel_i ? ADDR_HI : ADDR_LO;
  assign addr_hit  = (sh_q[BYTE_W-1:1] == own_addr);
  assign byte_end  = (state_q == ST_RX) && (cnt_q == CNT_FULL) && scl_fall && !start_det && !stop_det;

  assign sub_ld_o  = byte_end && (phase_q == PH_SUB);
  assign data_we_o = byte_end && (phase_q == PH_DATA);
  assign byte_o    = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADDR;
      rd_q    <= 1'b0;
      mack_q  <= 1'b1;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      cnt_q   <= '0;
      sh_q    <= '0;
      stat_q  <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_det) begin
        state_q <= ST_RX;
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise && cnt_q != CNT_FULL) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (byte_end) begin
              if (phase_q == PH_ADDR && !addr_hit) begin
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_ACK;
                if (phase_q == PH_ADDR) begin
                  rd_q <= sh_q[0];
                  if (sh_q[0]) stat_q <= status_i;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rd_q) begin
                state_q <= ST_TX;
                sh_q    <= stat_q;
              end else begin
                state_q <= ST_RX;
                phase_q <= (phase_q == PH_ADDR) ? PH_SUB : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (scl_fall) begin
              if (cnt_q == CNT_FULL) state_q <= ST_TXACK;
              else                   sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mack_q <= sda_i;
            end else if (scl_fall) begin
              if (!mack_q) begin
                state_q <= ST_TX;
                cnt_q   <= '0;
                stat_q  <= status_i;
                sh_q    <= status_i;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (state_q)
      ST_ACK:  sda_oe_o = 1'b1;
      ST_TX:   sda_oe_o = ~sh_q[BYTE_W-1];
      default: sda_oe_o = 1'b0;
    endcase
  end

  assign idle_o  = (state_q == ST_IDLE);
  assign rx_o    = (state_q == ST_RX);
  assign tx_o    = (state_q == ST_TX);
  assign start_o = start_det;
  assign stat_o  = stat_q;
endmodule

// File: rtl/vdec_ctrl_file.sv
`timescale 1ns/1ps
module vdec_ctrl_file
  import vdec_i2c_pkg::*;
#(
  parameter int unsigned NREG = NUM_REGS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sub_ld_i,
  input  logic                   data_we_i,
  input  logic [BYTE_W-1:0]      byte_i,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  logic [SUB_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (sub_ld_i)  ptr_q <= byte_i[SUB_W-1:0];
    else if (data_we_i) ptr_q <= ptr_q + SUB_W'(1);
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= reg_reset(k);
      else if (data_we_i && ptr_q == SUB_W'(k))   q <= byte_i;
    end
    assign regs_o[k*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/vdec_ctrl_regs.sv
`timescale 1ns/1ps
module vdec_ctrl_regs
  import vdec_i2c_pkg::*;
#(
  parameter int unsigned     NREG        = NUM_REGS,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [6:0]      ADDR_HI     = 7'h4D,
  parameter logic [6:0]      ADDR_LO     = 7'h4F
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  input  logic                   addr_sel_i,
  input  logic                   hlock_i,
  input  logic                   killer_i,
  input  logic                   pal_i,
  input  logic                   field50_i,
  input  logic                   secam_i,
  input  logic                   fsc443_i,
  output logic [NREG*BYTE_W-1:0] ctrl_o
);
  logic              scl_s, sda_s;
  logic              sub_ld, data_we, fsm_idle, fsm_rx, fsm_tx, start_det;
  logic [BYTE_W-1:0] rx_byte, stat_q, status;

  assign status = {hlock_i, killer_i, pal_i, field50_i, secam_i, fsc443_i, 2'b00};

  vdec_in_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_s, sda_s})
  );

  vdec_i2c_engine #(.ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .addr_sel_i (addr_sel_i),
    .status_i   (status),
    .sda_oe_o   (sda_oe_o),
    .sub_ld_o   (sub_ld),
    .data_we_o  (data_we),
    .byte_o     (rx_byte),
    .idle_o     (fsm_idle),
    .rx_o       (fsm_rx),
    .tx_o       (fsm_tx),
    .start_o    (start_det),
    .stat_o     (stat_q)
  );

  vdec_ctrl_file #(.NREG(NREG)) u_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sub_ld_i  (sub_ld),
    .data_we_i (data_we),
    .byte_i    (rx_byte),
    .regs_o    (ctrl_o)
  );
endmodule

// File: rtl/vdec_ctrl_regs_chk.sv
`timescale 1ns/1ps
module vdec_ctrl_regs_chk #(
  parameter int unsigned CTRL_W = 104
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              data_we_i,
  input logic              fsm_idle_i,
  input logic              fsm_rx_i,
  input logic              fsm_tx_i,
  input logic [7:0]        stat_i,
  input logic              start_i
);
  assert_oe_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_i);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_idle_i |-> !sda_oe_i);

  assert_ctrl_only_on_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_i) |-> $past(data_we_i));

  assert_status_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_tx_i && $past(fsm_tx_i)) |-> $stable(stat_i));

  assert_start_to_rx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> fsm_rx_i);
endmodule

bind vdec_ctrl_regs vdec_ctrl_regs_chk #(.CTRL_W(NREG*8)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_oe_i   (sda_oe_o),
  .ctrl_i     (ctrl_o),
  .data_we_i  (data_we),
  .fsm_idle_i (fsm_idle),
  .fsm_rx_i   (fsm_rx),
  .fsm_tx_i   (fsm_tx),
  .stat_i     (stat_q),
  .start_i    (start_det)
);

// File: tb/vdec_ctrl_regs_tb.sv
`timescale 1ns/1ps
module vdec_ctrl_regs_tb;
  localparam int Q  = 8;
  localparam int NR = 13;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, sel = 1'b1;
  logic [5:0] stat_pins = 6'b0;
  logic sda_oe;
  logic [NR*8-1:0] ctrl;
  wire sda_line = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  vdec_ctrl_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(sel), .hlock_i(stat_pins[5]), .killer_i(stat_pins[4]), .pal_i(stat_pins[3]),
    .field50_i(stat_pins[2]), .secam_i(stat_pins[1]), .fsc443_i(stat_pins[0]), .ctrl_o(ctrl)
  );

  // reference model
  logic [7:0] exp_reg [NR] = '{8'h7D, 8'h7C, 8'h77, 8'h77, 8'h74, 8'h78, 8'h77,
                               8'h77, 8'h78, 8'h79, 8'h78, 8'h00, 8'h14};
  logic [7:0] wq [$];
  int cyc = 0, hold_until = 0, mon_err = 0;
  int n_chk = 0, n_bad = 0;

  function automatic logic [NR*8-1:0] image();
    logic [NR*8-1:0] v;
    for (int k = 0; k < NR; k++) v[k*8 +: 8] = exp_reg[k];
    return v;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && cyc > hold_until && ctrl !== image()) mon_err <= mon_err + 1;

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1; wt(Q); m_scl = 1; wt(Q); m_sda = 0; wt(Q); m_scl = 0; wt(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 0; wt(Q); m_scl = 1; wt(Q); m_sda = 1; wt(Q);
  endtask

  task automatic bit_w(input logic b);
    m_sda = b; wt(Q); m_scl = 1; wt(2*Q); m_scl = 0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit commit, input int idx, output logic ack);
    for (int i = 7; i >= 1; i--) bit_w(v[i]);
    m_sda = v[0]; wt(Q); m_scl = 1; wt(2*Q);
    if (commit) begin
      hold_until = cyc + 12;
      exp_reg[idx] = v;
    end
    m_scl = 0; wt(Q);
    m_sda = 1; wt(Q); m_scl = 1; wt(Q); ack = sda_line; wt(Q); m_scl = 0; wt(Q);
  endtask

  task automatic recv_byte(input logic mack, input int chg_at, input logic [5:0] chg_val,
                           output logic [7:0] v);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); m_scl = 1; wt(Q); v[i] = sda_line; wt(Q); m_scl = 0; wt(Q);
      if (i == chg_at) stat_pins = chg_val;
    end
    m_sda = mack; wt(Q); m_scl = 1; wt(2*Q); m_scl = 0; wt(Q);
  endtask

  task automatic check_image(input string req);
    chk({req, " register image"}, ctrl, image());
    chk({req, " per-cycle image mismatches"}, mon_err, 0);
  endtask

  task automatic do_write(input logic [7:0] ab, input logic [7:0] sub, input bit hit,
                          input string req);
    logic a;
    int ptr;
    i2c_start();
    send_byte(ab, 0, 0, a);  chk({req, " address ack"}, a, !hit);
    send_byte(sub, 0, 0, a); chk({req, " index ack"}, a, !hit);
    ptr = int'(sub[3:0]);
    foreach (wq[i]) begin
      send_byte(wq[i], hit && ptr < NR, ptr, a);
      chk({req, " data ack"}, a, !hit);
      ptr = (ptr + 1) % 16;
    end
    i2c_stop(); wt(4);
    check_image(req);
  endtask

  task automatic do_read(input logic [7:0] ab, input int nb, input int chg_at,
                         input logic [5:0] chg_val, input string req);
    logic a;
    logic [7:0] v, e;
    i2c_start();
    send_byte(ab, 0, 0, a); chk({req, " read address ack"}, a, 1'b0);
    for (int k = 0; k < nb; k++) begin
      e = {stat_pins, 2'b00};
      recv_byte(k == nb - 1, (k == 0) ? chg_at : -1, chg_val, v);
      chk({req, " status byte"}, v, e);
    end
    wt(Q);
    chk("R7 SDA released after NACK", sda_oe, 1'b0);
    for (int p = 0; p < 9; p++) begin
      m_sda = 1; wt(Q); m_scl = 1; wt(Q);
      if (p == 4) chk("R7 no drive on clocks after NACK", sda_line, 1'b1);
      wt(Q); m_scl = 0; wt(Q);
    end
    i2c_stop(); wt(4);
  endtask

  initial begin
    wait (cyc >= 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] v, e;
    wt(5); rst_n = 1; wt(4);
    chk("R1 reset image", ctrl, image());
    chk("R1 SDA released at reset", sda_oe, 1'b0);

    // R4 single lane writes
    wq = '{8'hA5, 8'h3C, 8'h0F};
    do_write(8'h9A, 8'h00, 1, "R4 burst from 0x0");
    // R5 auto-increment through 0xC and beyond
    wq = '{8'h11, 8'h22, 8'h33, 8'h44};
    do_write(8'h9A, 8'h0B, 1, "R5 run past 0xC");
    wq = '{8'hE1};
    do_write(8'h9A, 8'h0E, 1, "R5 index 0xE discarded");
    // R3 upper nibble ignored
    wq = '{8'h5A};
    do_write(8'h9A, 8'hF3, 1, "R3 index 0xF3");
    // R2 wrong address for select high
    wq = '{8'hFF};
    do_write(8'h9E, 8'h04, 0, "R2 select high rejects 0x9E");
    sel = 0; wt(4);
    wq = '{8'h66};
    do_write(8'h9E, 8'h08, 1, "R2 select low accepts 0x9E");
    wq = '{8'h77};
    do_write(8'h9A, 8'h08, 0, "R2 select low rejects 0x9A");

    // R6 reads
    stat_pins = 6'b101101;
    do_read(8'h9F, 1, -1, 6'b0, "R6 single read");
    stat_pins = 6'b110010;
    do_read(8'h9F, 2, 4, 6'b001101, "R6 latched during byte");
    sel = 1; wt(4);
    stat_pins = 6'b010110;
    do_read(8'h9B, 3, -1, 6'b0, "R6 multi read select high");

    // R8 repeated START between two writes
    i2c_start();
    send_byte(8'h9A, 0, 0, a); chk("R8 first address ack", a, 1'b0);
    send_byte(8'h00, 0, 0, a);
    send_byte(8'h11, 1, 0, a); chk("R8 first data ack", a, 1'b0);
    i2c_start();
    send_byte(8'h9A, 0, 0, a); chk("R8 repeated address ack", a, 1'b0);
    send_byte(8'h06, 0, 0, a);
    send_byte(8'h22, 1, 6, a); chk("R8 second data ack", a, 1'b0);
    i2c_stop(); wt(4);
    check_image("R8 repeated start write");

    // R8 repeated START into a read
    stat_pins = 6'b111000;
    i2c_start();
    send_byte(8'h9A, 0, 0, a);
    send_byte(8'h05, 0, 0, a);
    i2c_start();
    send_byte(8'h9B, 0, 0, a); chk("R8 read after repeated start ack", a, 1'b0);
    e = {stat_pins, 2'b00};
    recv_byte(1'b1, -1, 6'b0, v);
    chk("R8 status after repeated start", v, e);
    i2c_stop(); wt(4);
    check_image("R8 index-only frame");

    // R8 STOP mid-byte
    i2c_start();
    send_byte(8'h9A, 0, 0, a);
    send_byte(8'h02, 0, 0, a);
    bit_w(1); bit_w(0); bit_w(1); bit_w(0);
    i2c_stop(); wt(4);
    check_image("R8 partial byte discarded");
    wq = '{8'hC3};
    do_write(8'h9A, 8'h02, 1, "R8 recovery after abort");
    chk("R9 SDA released at end", sda_oe, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule